// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Programmable Receive Sampling

This block is a serial port peripheral reached over a simple 32-bit register bus. Software writes characters into a 16-entry transmit queue, and they leave on `txd` as asynchronous frames. Characters that arrive on `rxd` are checked and placed in a 16-entry receive queue. Software reads them out one at a time. The frame has 5 to 8 data bits, an optional parity bit of either sense, and one or two stop bits. It is set up through a single configuration word.

The bit period is a whole count of input clocks. Software sets it to the clock frequency divided by the baud rate. A second register sets the clock count, within each received bit, at which the receiver reads the line. Software normally sets this to half the period, with a minimum of 7.

Queue status flags are available, along with seven latched event sources and two enable masks. Each mask drives its own interrupt line. The slots for flow control and clock fine-tune are not implemented and read as zero.

Top module: `sercom_top`

## Requirements
- R1: Word offsets are: 0x00 config, 0x04 flow control, 0x08 receive sample count, 0x0C fine-tune, 0x10 transmit data, 0x14 receive data, 0x18 status, 0x1C enable mask A, 0x20 enable mask B, 0x24 and 0x28 event clear, 0x2C event status. Config and the masks reset to zero. The slots at 0x04 and 0x0C always read zero. A read strobe returns its data on `bus_rdata` one cycle later.
- R2: Config bit 7 is the master enable, bit 6 enables the receiver and bit 5 enables the transmitter. The transmitter starts a frame only while bits 7 and 5 are both set. The receiver accepts frames only while bits 7 and 6 are both set.
- R3: A transmitted frame is a low start bit, then the data bits LSB first, then the parity bit if enabled, then one high stop bit, or two if config bit 2 is set. Each bit lasts config[31:8] clocks. Config[1:0] gives the data length: 0 is 5 bits, 1 is 6, 2 is 7 and 3 is 8. Unused high bits of the written byte are not sent.
- R4: Config bit 4 adds a parity bit. Config bit 3 set gives even parity and clear gives odd parity. Parity covers only the configured data bits.
- R5: The receiver reads each bit when its in-bit counter equals the value at 0x08. It stores the character right-justified, with bits above the length at zero.
- R6: A start edge whose line is back high at the sample point is dropped as a glitch. No character is stored and no event is raised.
- R7: A read of 0x14 returns the oldest received character in bits 7:0 and removes it from the queue.
- R8: Status 0x18 holds transmit-empty in bit 3, transmit-full in bit 2, receive-empty in bit 1 and receive-full in bit 0. It reads 0x0A after reset.
- R9: Both queues hold 16 entries. A transmit write while full is dropped and latches event bit 0. A received character that meets a full queue is dropped and latches event bit 3.
- R10: A read of 0x14 while the receive queue is empty returns zero and latches event bit 4.
- R11: A bad parity bit latches event bit 2. A low stop bit latches event bit 1. The character is still stored.
- R12: Event bit 6 is set on every cycle the receive queue is non-empty, and bit 5 on every cycle the transmit queue is empty. Writing a 1 to a bit at 0x24 or 0x28 clears that latched event. A set in the same cycle wins over the clear.
- R13: `irq_a` is the registered OR of the latched events ANDed with mask A. `irq_b` does the same with mask B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, high when idle |
| irq_a | output | 1 | Interrupt gated by mask A |
| irq_b | output | 1 | Interrupt gated by mask B |

## Verification
The bench goes after the following corner cases:
- **Short length with parity.** It sends five-bit and seven-bit frames with parity. A design that computed parity over all eight bits, or shipped the high bits, would show a wrong parity bit or extra data bits on the line.
- **Brief low pulse.** It drives a pulse shorter than the sample point. A receiver without the re-check would store a spurious 0xFF or raise a stop error.
- **Queue boundaries.** It sends a seventeenth character into each full queue and reads an empty receive queue. An off-by-one queue would overwrite its oldest entry or lose the event bit.
- **Clear against a live source.** It clears event bit 6 while the receive queue is still non-empty. A design that let the clear win would lose the level event.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  localparam logic [7:0] OFF_CFG   = 8'h00;
  localparam logic [7:0] OFF_FLOW  = 8'h04;
  localparam logic [7:0] OFF_SAMP  = 8'h08;
  localparam logic [7:0] OFF_TUNE  = 8'h0C;
  localparam logic [7:0] OFF_TXD   = 8'h10;
  localparam logic [7:0] OFF_RXD   = 8'h14;
  localparam logic [7:0] OFF_STAT  = 8'h18;
  localparam logic [7:0] OFF_MASKA = 8'h1C;
  localparam logic [7:0] OFF_MASKB = 8'h20;
  localparam logic [7:0] OFF_CLR0  = 8'h24;
  localparam logic [7:0] OFF_CLR1  = 8'h28;
  localparam logic [7:0] OFF_EVT   = 8'h2C;

  localparam int EV_RX_AVAIL = 6;
  localparam int EV_TX_IDLE  = 5;
  localparam int EV_RX_UNDER = 4;
  localparam int EV_RX_OVER  = 3;
  localparam int EV_PAR_BAD  = 2;
  localparam int EV_STOP_BAD = 1;
  localparam int EV_TX_OVER  = 0;
  localparam int EV_W        = 7;

  typedef struct packed {
    logic [23:0] div;
    logic        on;
    logic        rx_on;
    logic        tx_on;
    logic        par_on;
    logic        par_even;
    logic        stop_two;
    logic [1:0]  len;
  } cfg_t;

endpackage

// File: rtl/sercom_fifo.sv
module sercom_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0]   CNT_ONE  = (AW+1)'(1);
  localparam logic [AW-1:0] PTR_ONE  = AW'(1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_wr, do_rd;

  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= wp + PTR_ONE;
      if (do_rd) rp <= rp + PTR_ONE;
      unique case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + CNT_ONE;
        2'b01:   cnt <= cnt - CNT_ONE;
        default: ;
      endcase
    end
  end

  // R9: a push into a full queue with no pop leaves it full and unchanged in size
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (cnt == FULL_CNT));
  // R10: a pop from an empty queue does not wrap the count
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);

endmodule

// File: rtl/sercom_tx.sv
module sercom_tx #(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DIV_W-1:0] div,
  input  logic [1:0]       len,
  input  logic             par_on,
  input  logic             par_even,
  input  logic             stop_two,
  input  logic             q_empty,
  input  logic [7:0]       q_data,
  output logic             q_pop,
  output logic             txd
);
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_t;

  tst_t             st;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bidx;
  logic [7:0]       sh;
  logic             pbit;
  logic             second;
  logic             bit_end;
  logic [2:0]       last_idx;
  logic [7:0]       mask;
  logic             ones;

  assign bit_end  = (cnt >= div - DIV_W'(1));
  assign last_idx = 3'(len) + 3'd4;
  assign mask     = 8'hFF >> (2'd3 - len);
  assign ones     = ^(q_data & mask);
  assign q_pop    = (st == T_IDLE) && go && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= T_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sh     <= '0;
      pbit   <= 1'b0;
      second <= 1'b0;
      txd    <= 1'b1;
    end else if (st == T_IDLE) begin
      txd <= 1'b1;
      if (q_pop) begin
        st     <= T_START;
        cnt    <= '0;
        sh     <= q_data;
        pbit   <= par_even ? ones : !ones;
        second <= 1'b0;
        txd    <= 1'b0;
      end
    end else if (!bit_end) begin
      cnt <= cnt + DIV_W'(1);
    end else begin
      cnt <= '0;
      unique case (st)
        T_START: begin
          st   <= T_DATA;
          bidx <= '0;
          txd  <= sh[0];
          sh   <= sh >> 1;
        end
        T_DATA: begin
          if (bidx == last_idx) begin
            if (par_on) begin
              st  <= T_PAR;
              txd <= pbit;
            end else begin
              st  <= T_STOP;
              txd <= 1'b1;
            end
          end else begin
            bidx <= bidx + 3'd1;
            txd  <= sh[0];
            sh   <= sh >> 1;
          end
        end
        T_PAR: begin
          st  <= T_STOP;
          txd <= 1'b1;
        end
        T_STOP: begin
          if (stop_two && !second) second <= 1'b1;
          else st <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  // R3: taking a character from the queue drives the start bit low on the next cycle
  a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
    q_pop |=> !txd);
  // R3: the line is high whenever the transmitter is back in idle
  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    (st == T_IDLE) |-> txd);

endmodule

// File: rtl/sercom_rx.sv
module sercom_rx #(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             rxd,
  input  logic [DIV_W-1:0] div,
  input  logic [DIV_W-1:0] samp,
  input  logic [1:0]       len,
  input  logic             par_on,
  input  logic             par_even,
  input  logic             stop_two,
  output logic             push,
  output logic [7:0]       data,
  output logic             par_bad,
  output logic             stop_bad
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rst_t;

  rst_t             st;
  logic             s1, s2, s3;
  logic             line, fall;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bidx;
  logic [7:0]       sh;
  logic [7:0]       aligned;
  logic             pexp;
  logic             second, perr_a, serr_a;
  logic             at_samp, bit_end;
  logic [2:0]       last_idx;

  assign line     = s2;
  assign fall     = s3 && !s2;
  assign at_samp  = (cnt == samp);
  assign bit_end  = (cnt >= div - DIV_W'(1));
  assign last_idx = 3'(len) + 3'd4;
  assign aligned  = sh >> (2'd3 - len);
  assign pexp     = par_even ? ^aligned : !(^aligned);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= R_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      sh       <= '0;
      second   <= 1'b0;
      perr_a   <= 1'b0;
      serr_a   <= 1'b0;
      push     <= 1'b0;
      data     <= '0;
      par_bad  <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      push <= 1'b0;
      if (!go) begin
        st <= R_IDLE;
      end else if (st == R_IDLE) begin
        if (fall) begin
          st     <= R_START;
          cnt    <= '0;
          bidx   <= '0;
          second <= 1'b0;
          perr_a <= 1'b0;
          serr_a <= 1'b0;
        end
      end else begin
        cnt <= bit_end ? '0 : cnt + DIV_W'(1);
        unique case (st)
          R_START: begin
            if (at_samp && line) st <= R_IDLE;
            else if (bit_end)    st <= R_DATA;
          end
          R_DATA: begin
            if (at_samp) sh <= {line, sh[7:1]};
            if (bit_end) begin
              if (bidx == last_idx) st <= par_on ? R_PAR : R_STOP;
              else bidx <= bidx + 3'd1;
            end
          end
          R_PAR: begin
            if (at_samp) perr_a <= (line != pexp);
            if (bit_end) st <= R_STOP;
          end
          R_STOP: begin
            if (at_samp) begin
              if (stop_two && !second) begin
                serr_a <= serr_a | !line;
              end else begin
                st       <= R_IDLE;
                push     <= 1'b1;
                data     <= aligned;
                par_bad  <= perr_a;
                stop_bad <= serr_a | !line;
              end
            end else if (bit_end) begin
              second <= 1'b1;
            end
          end
          default: st <= R_IDLE;
        endcase
      end
    end
  end

  // R6: a line found high at the start-bit sample point drops the frame with no store
  a_r6_glitch_drop: assert property (@(posedge clk) disable iff (rst)
    (go && st == R_START && at_samp && line) |=> (st == R_IDLE && !push));
  // R2: a disabled receiver stores nothing
  a_r2_rx_gated: assert property (@(posedge clk) disable iff (rst)
    !go |=> !push);

endmodule

// File: rtl/sercom_top.sv
module sercom_top
  import sercom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_a,
  output logic              irq_b
);
  localparam int DIV_W = 24;

  cfg_t             cfg;
  logic [DIV_W-1:0] samp;
  logic [EV_W-1:0]  mask_a, mask_b, lat, set_v, clr_v;
  logic [7:0]       a8;

  logic       tx_push, tx_pop, tx_empty, tx_full;
  logic [7:0] tx_q;
  logic       rx_pop, rx_empty, rx_full;
  logic [7:0] rx_q;
  logic       rx_push, rx_pbad, rx_sbad;
  logic [7:0] rx_char;
  logic       tx_go, rx_go;

  assign a8      = 8'(bus_addr);
  assign tx_push = bus_wr && (a8 == OFF_TXD);
  assign rx_pop  = bus_rd && (a8 == OFF_RXD);
  assign tx_go   = cfg.on && cfg.tx_on;
  assign rx_go   = cfg.on && cfg.rx_on;

  sercom_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_q), .empty(tx_empty), .full(tx_full));

  sercom_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_char),
    .pop(rx_pop), .dout(rx_q), .empty(rx_empty), .full(rx_full));

  sercom_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst(rst), .go(tx_go), .div(cfg.div), .len(cfg.len),
    .par_on(cfg.par_on), .par_even(cfg.par_even), .stop_two(cfg.stop_two),
    .q_empty(tx_empty), .q_data(tx_q), .q_pop(tx_pop), .txd(txd));

  sercom_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst(rst), .go(rx_go), .rxd(rxd), .div(cfg.div), .samp(samp),
    .len(cfg.len), .par_on(cfg.par_on), .par_even(cfg.par_even),
    .stop_two(cfg.stop_two), .push(rx_push), .data(rx_char),
    .par_bad(rx_pbad), .stop_bad(rx_sbad));

  always_comb begin
    set_v              = '0;
    set_v[EV_RX_AVAIL] = !rx_empty;
    set_v[EV_TX_IDLE]  = tx_empty;
    set_v[EV_RX_UNDER] = rx_pop && rx_empty;
    set_v[EV_RX_OVER]  = rx_push && rx_full;
    set_v[EV_PAR_BAD]  = rx_push && rx_pbad;
    set_v[EV_STOP_BAD] = rx_push && rx_sbad;
    set_v[EV_TX_OVER]  = tx_push && tx_full;
    clr_v = (bus_wr && (a8 == OFF_CLR0 || a8 == OFF_CLR1)) ? bus_wdata[EV_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      samp   <= '0;
      mask_a <= '0;
      mask_b <= '0;
      lat    <= '0;
      irq_a  <= 1'b0;
      irq_b  <= 1'b0;
    end else begin
      if (bus_wr) begin
        unique case (a8)
          OFF_CFG:   cfg    <= cfg_t'(bus_wdata);
          OFF_SAMP:  samp   <= bus_wdata[DIV_W-1:0];
          OFF_MASKA: mask_a <= bus_wdata[EV_W-1:0];
          OFF_MASKB: mask_b <= bus_wdata[EV_W-1:0];
          default: ;
        endcase
      end
      lat   <= (lat & ~clr_v) | set_v;
      irq_a <= |(lat & mask_a);
      irq_b <= |(lat & mask_b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (a8)
        OFF_CFG:   bus_rdata <= cfg;
        OFF_SAMP:  bus_rdata <= 32'(samp);
        OFF_RXD:   bus_rdata <= rx_empty ? 32'd0 : 32'(rx_q);
        OFF_STAT:  bus_rdata <= {28'd0, tx_empty, tx_full, rx_empty, rx_full};
        OFF_MASKA: bus_rdata <= 32'(mask_a);
        OFF_MASKB: bus_rdata <= 32'(mask_b);
        OFF_CLR0, OFF_CLR1, OFF_EVT: bus_rdata <= 32'(lat);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  // R12: a clear with no concurrent set removes the latched event
  a_r12_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && a8 == OFF_CLR0 && bus_wdata[EV_RX_UNDER] && !set_v[EV_RX_UNDER])
      |=> !lat[EV_RX_UNDER]);
  // R12: a set in the same cycle as a clear wins
  a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_v[EV_RX_OVER] |=> lat[EV_RX_OVER]);
  // R2: no character leaves the queue while the transmitter is disabled
  a_r2_tx_gated: assert property (@(posedge clk) disable iff (rst)
    !tx_go |-> !tx_pop);

endmodule

// File: tb/sercom_top_tb.sv
module sercom_top_tb;
  localparam int DIV  = 16;
  localparam int SAMP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rxd = 1'b1;
  logic        txd, irq_a, irq_b;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  int m_nb = 8, m_par = 0, m_even = 0, m_two = 0;

  always #2 clk = ~clk;

  sercom_top u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
    .irq_a(irq_a), .irq_b(irq_b));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[5:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a[5:0];
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] cfgw(int len, int pe, int ev, int two, int rxo, int txo);
    return {24'(DIV), 1'b1, 1'(rxo), 1'(txo), 1'(pe), 1'(ev), 1'(two), 2'(len)};
  endfunction

  task automatic send(logic [7:0] d, int nb, int pe, int ev, int two,
                      int bad_par, int bad_stop);
    logic p;
    p = 1'b0;
    @(negedge clk);
    rxd = 1'b0; repeat (DIV) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i]; p = p ^ d[i];
      repeat (DIV) @(negedge clk);
    end
    if (pe != 0) begin
      rxd = (ev != 0) ? p : !p;
      if (bad_par != 0) rxd = !rxd;
      repeat (DIV) @(negedge clk);
    end
    rxd = (bad_stop != 0) ? 1'b0 : 1'b1;
    repeat (DIV) @(negedge clk);
    rxd = 1'b1;
    if (two != 0) repeat (DIV) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_tx;
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (3 * DIV) @(negedge clk);
  endtask

  // Monitor: decodes txd frames and compares them with the scoreboard queue (R3, R4)
  initial begin
    logic [7:0] got, ex;
    logic pb, ep, stop_ok;
    forever begin
      @(negedge clk);
      if (!rst && txd === 1'b0) begin
        repeat (DIV / 2) @(negedge clk);
        got = '0; stop_ok = (txd === 1'b0);
        for (int i = 0; i < m_nb; i++) begin
          repeat (DIV) @(negedge clk);
          got[i] = txd;
        end
        pb = 1'b0;
        if (m_par != 0) begin repeat (DIV) @(negedge clk); pb = txd; end
        repeat (DIV) @(negedge clk);
        if (txd !== 1'b1) stop_ok = 1'b0;
        if (m_two != 0) begin
          repeat (DIV) @(negedge clk);
          if (txd !== 1'b1) stop_ok = 1'b0;
        end
        if (exp_q.size() == 0) begin
          chk("R3 unexpected frame", {24'd0, got}, 32'hFFFF_FFFF);
        end else begin
          ex = exp_q.pop_front();
          ep = (m_par != 0) ? ((m_even != 0) ? ^ex : !(^ex)) : 1'b0;
          chk("R3/R4 tx frame", {22'd0, stop_ok, pb, got}, {22'd0, 1'b1, ep, ex});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1, R8, R13: reset state
    chk("R3 idle line", {31'd0, txd}, 32'd1);
    chk("R13 irq reset", {30'd0, irq_a, irq_b}, 32'd0);
    rd(8'h00, d); chk("R1 cfg reset", d, 32'd0);
    rd(8'h18, d); chk("R8 status reset", d, 32'h0A);
    rd(8'h04, d); chk("R1 flow slot", d, 32'd0);
    rd(8'h0C, d); chk("R1 tune slot", d, 32'd0);

    wr(8'h08, SAMP);
    // R3: 8 data bits, no parity, one stop
    m_nb = 8; m_par = 0; m_even = 0; m_two = 0;
    wr(8'h00, cfgw(3, 0, 0, 0, 1, 1));
    exp_q.push_back(8'hA5); exp_q.push_back(8'h3C);
    wr(8'h10, 32'hA5); wr(8'h10, 32'h3C);
    wait_tx();
    rd(8'h18, d); chk("R8 tx empty after send", d & 32'h0C, 32'h08);

    // R3, R4: 5 bits, even parity, two stops; upper bits not sent
    m_nb = 5; m_par = 1; m_even = 1; m_two = 1;
    wr(8'h00, cfgw(0, 1, 1, 1, 1, 1));
    exp_q.push_back(8'h13); wr(8'h10, 32'hF3);
    wait_tx();
    // R4: 7 bits, odd parity
    m_nb = 7; m_par = 1; m_even = 0; m_two = 0;
    wr(8'h00, cfgw(2, 1, 0, 0, 1, 1));
    exp_q.push_back(8'h55); wr(8'h10, 32'h55);
    wait_tx();

    // R5, R7: receive 8N1
    wr(8'h00, cfgw(3, 0, 0, 0, 1, 1));
    send(8'h96, 8, 0, 0, 0, 0, 0);
    rd(8'h18, d); chk("R8 rx non-empty", d & 32'h2, 32'h0);
    rd(8'h14, d); chk("R5/R7 rx data", d, 32'h96);
    rd(8'h18, d); chk("R7 popped", d & 32'h2, 32'h2);

    // R4, R11: 7 bits odd parity, good then bad
    wr(8'h00, cfgw(2, 1, 0, 0, 1, 1));
    wr(8'h24, 32'h7F);
    send(8'h35, 7, 1, 0, 0, 0, 0);
    rd(8'h14, d); chk("R5 7-bit rx", d, 32'h35);
    rd(8'h2C, d); chk("R11 good parity no event", d & 32'h4, 32'h0);
    send(8'h2A, 7, 1, 0, 0, 1, 0);
    rd(8'h2C, d); chk("R11 parity event", d & 32'h4, 32'h4);
    rd(8'h14, d); chk("R11 char kept on parity error", d, 32'h2A);

    // R11: stop error
    wr(8'h00, cfgw(3, 0, 0, 0, 1, 1));
    wr(8'h24, 32'h7F);
    send(8'h11, 8, 0, 0, 0, 0, 1);
    rd(8'h2C, d); chk("R11 stop event", d & 32'h2, 32'h2);
    rd(8'h14, d); chk("R11 char kept on stop error", d, 32'h11);

    // R6: glitch
    wr(8'h24, 32'h7F);
    @(negedge clk); rxd = 1'b0; repeat (3) @(negedge clk); rxd = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    rd(8'h18, d); chk("R6 glitch no char", d & 32'h2, 32'h2);
    rd(8'h2C, d); chk("R6 glitch no event", d & 32'h4E, 32'h0);

    // R10, R12: underrun and clear through the second clear slot
    rd(8'h14, d); chk("R10 empty read value", d, 32'h0);
    rd(8'h2C, d); chk("R10 underrun event", d & 32'h10, 32'h10);
    wr(8'h28, 32'h10);
    rd(8'h2C, d); chk("R12 clear", d & 32'h10, 32'h0);

    // R12: level source re-sets while the queue is non-empty
    send(8'h42, 8, 0, 0, 0, 0, 0);
    wr(8'h24, 32'h40);
    rd(8'h2C, d); chk("R12 level persists", d & 32'h40, 32'h40);
    rd(8'h14, d); chk("R7 data", d, 32'h42);
    wr(8'h24, 32'h40);
    rd(8'h2C, d); chk("R12 level cleared", d & 32'h40, 32'h0);

    // R13: interrupt masks
    wr(8'h1C, 32'h10);
    rd(8'h14, d);
    repeat (3) @(negedge clk);
    chk("R13 irq_a on, irq_b off", {30'd0, irq_a, irq_b}, 32'h2);
    wr(8'h20, 32'h10);
    repeat (3) @(negedge clk);
    chk("R13 irq_b on", {31'd0, irq_b}, 32'h1);
    wr(8'h24, 32'h10);
    repeat (3) @(negedge clk);
    chk("R13 irqs off after clear", {30'd0, irq_a, irq_b}, 32'h0);
    wr(8'h1C, 32'h0); wr(8'h20, 32'h0);

    // R2, R9: transmit disabled, overfill the queue
    m_nb = 8; m_par = 0; m_even = 0; m_two = 0;
    wr(8'h00, cfgw(3, 0, 0, 0, 1, 0));
    wr(8'h24, 32'h7F);
    for (int i = 0; i < 17; i++) wr(8'h10, 32'(i));
    repeat (2 * DIV) @(negedge clk);
    chk("R2 tx disabled line idle", {31'd0, txd}, 32'd1);
    rd(8'h18, d); chk("R9 tx full", d & 32'h4, 32'h4);
    rd(8'h2C, d); chk("R9 tx overrun event", d & 32'h1, 32'h1);
    for (int i = 0; i < 16; i++) exp_q.push_back(8'(i));
    wr(8'h00, cfgw(3, 0, 0, 0, 1, 1));
    wait_tx();
    chk("R9 all queued frames sent", 32'(exp_q.size()), 32'd0);

    // R9: receive overrun
    wr(8'h24, 32'h7F);
    for (int i = 0; i < 17; i++) send(8'(8'h80 + i), 8, 0, 0, 0, 0, 0);
    rd(8'h18, d); chk("R8 rx full", d & 32'h1, 32'h1);
    rd(8'h2C, d); chk("R9 rx overrun event", d & 32'h8, 32'h8);
    for (int i = 0; i < 16; i++) begin
      rd(8'h14, d); chk("R9 rx queue order", d, 32'(8'h80 + i));
    end
    rd(8'h18, d); chk("R8 rx empty after drain", d & 32'h3, 32'h2);

    // R2: receiver disabled
    wr(8'h00, cfgw(3, 0, 0, 0, 0, 1));
    wr(8'h24, 32'h7F);
    send(8'h77, 8, 0, 0, 0, 0, 0);
    rd(8'h18, d); chk("R2 rx disabled no char", d & 32'h2, 32'h2);
    rd(8'h2C, d); chk("R2 rx disabled no event", d & 32'h40, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule